// File: doc/BRIEF.md
# Keyboard Scancode to ASCII Translator

This block sits behind a keyboard receiver that has already turned the serial keyboard line into whole bytes, set-2 scancodes, one byte per cycle of `byte_valid`. It follows the key-down and key-up traffic and turns each key press into one 7-bit ASCII character. The character comes out on `char_code` with a single-cycle `char_valid` strobe, one clock after the byte that caused it.

Both shift keys are tracked through their press and release codes. A release is announced by a 0xF0 byte in front of the key's code. Releases never produce characters. Character lookup uses an internal 256-entry ROM that is built at elaboration. The lower half holds the plain characters and the upper half holds the shifted ones, and both halves are indexed by the key code. Keys whose entry is zero, such as the control keys and the function keys, produce nothing.

Sequences that start with the 0xE0 prefix are swallowed whole. So is the eight-byte Pause sequence that starts with 0xE1. A held key sends its code again and again, and each repeat gives one more character.

Top module: `kbd_ascii_xlate`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the shift state, the last-byte memory and any skip in progress. After reset `char_valid` is 0 and `char_code` is 0.
- R2: A key tap `K`, 0xF0, `K` produces exactly one character, in the cycle after `K` is first accepted. For example 0x4B 0xF0 0x4B gives 0x6C. A code byte that directly follows 0xF0 produces no output.
- R3: Code 0x12 or code 0x59 that does not follow 0xF0 sets the shift state, and later keys then read the shifted half of the ROM. For example 0x12 0x4B gives 0x4C, and 0x59 0x15 gives 0x51.
- R4: The sequence 0xF0 0x12 or 0xF0 0x59 clears the shift state, so the next key press reads the plain half. For example 0x16 then gives 0x31.
- R5: Each repeated code byte of a held key (a code that does not follow 0xF0) gives one more character. Back-to-back bytes give strobes in back-to-back cycles.
- R6: A key whose ROM entry is 0x00 gives no strobe. Examples are 0x14 and 0x05.
- R7: Byte 0xE0 starts an extended sequence. Every byte after it is dropped up to and including the first byte that is not 0xF0. No strobe is produced and the shift state does not change.
- R8: Byte 0xE1 drops itself and the next 7 bytes (`PAUSE_TAIL`) with no strobe and no change to the shift state. The byte that follows is decoded normally.
- R9: `char_valid` is high for exactly one cycle for each byte that produces a character. It rises one clock after the edge at which that byte is accepted.
- R10: Any other byte with bit 7 set, such as 0xAA, produces no strobe.
- R11: While `byte_valid` is low, `byte_data` is ignored and no strobe is produced.
- R12: Shifted punctuation and the control characters come from the ROM. 0x12 0x0E gives 0x7E, and 0x5A gives 0x0D whether or not shift is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| byte_valid | input | 1 | Qualifies `byte_data` for one cycle |
| byte_data | input | 8 | Scancode byte from the receiver |
| char_valid | output | 1 | One-cycle strobe for a new character |
| char_code | output | 7 | ASCII character, held between strobes |

## Verification
A corrupted last-byte memory shows up on the very next key byte. Either a key release produces an unwanted character, or a press is silently dropped, and the strobe appears or goes missing one clock later. A wrong shift state changes the case of the next letter. A skip counter that is off by one either eats the first real key after Pause or lets a Pause byte through. To expose this, the stimulus always places a printable key directly after each shift change, each extended sequence and each Pause sequence.

// File: rtl/kbd_ascii_xlate.sv
module kbd_ascii_xlate #(
  parameter int PAUSE_TAIL = 7
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       byte_valid,
  input  logic [7:0] byte_data,
  output logic       char_valid,
  output logic [6:0] char_code
);
  localparam int CW = $clog2(PAUSE_TAIL + 1);
  localparam logic [7:0] BRK = 8'hF0, PFX_EXT = 8'hE0, PFX_PAU = 8'hE1;
  localparam logic [7:0] SH_L = 8'h12, SH_R = 8'h59;

  typedef enum logic [1:0] {M_NORM = 2'd0, M_EXT = 2'd1, M_PAUSE = 2'd2} mode_t;

  function automatic logic [6:0] plain_key(input logic [6:0] c);
    case (c)
      7'h1C: return 7'h61; 7'h32: return 7'h62; 7'h21: return 7'h63; 7'h23: return 7'h64;
      7'h24: return 7'h65; 7'h2B: return 7'h66; 7'h34: return 7'h67; 7'h33: return 7'h68;
      7'h43: return 7'h69; 7'h3B: return 7'h6A; 7'h42: return 7'h6B; 7'h4B: return 7'h6C;
      7'h3A: return 7'h6D; 7'h31: return 7'h6E; 7'h44: return 7'h6F; 7'h4D: return 7'h70;
      7'h15: return 7'h71; 7'h2D: return 7'h72; 7'h1B: return 7'h73; 7'h2C: return 7'h74;
      7'h3C: return 7'h75; 7'h2A: return 7'h76; 7'h1D: return 7'h77; 7'h22: return 7'h78;
      7'h35: return 7'h79; 7'h1A: return 7'h7A;
      7'h45: return 7'h30; 7'h16: return 7'h31; 7'h1E: return 7'h32; 7'h26: return 7'h33;
      7'h25: return 7'h34; 7'h2E: return 7'h35; 7'h36: return 7'h36; 7'h3D: return 7'h37;
      7'h3E: return 7'h38; 7'h46: return 7'h39;
      7'h0E: return 7'h60; 7'h4E: return 7'h2D; 7'h55: return 7'h3D; 7'h54: return 7'h5B;
      7'h5B: return 7'h5D; 7'h5D: return 7'h5C; 7'h4C: return 7'h3B; 7'h52: return 7'h27;
      7'h41: return 7'h2C; 7'h49: return 7'h2E; 7'h4A: return 7'h2F;
      7'h29: return 7'h20; 7'h5A: return 7'h0D; 7'h0D: return 7'h09; 7'h66: return 7'h08;
      7'h76: return 7'h1B;
      default: return 7'h00;
    endcase
  endfunction

  function automatic logic [6:0] shift_key(input logic [6:0] c);
    logic [6:0] p;
    case (c)
      7'h45: return 7'h29; 7'h16: return 7'h21; 7'h1E: return 7'h40; 7'h26: return 7'h23;
      7'h25: return 7'h24; 7'h2E: return 7'h25; 7'h36: return 7'h5E; 7'h3D: return 7'h26;
      7'h3E: return 7'h2A; 7'h46: return 7'h28;
      7'h0E: return 7'h7E; 7'h4E: return 7'h5F; 7'h55: return 7'h2B; 7'h54: return 7'h7B;
      7'h5B: return 7'h7D; 7'h5D: return 7'h7C; 7'h4C: return 7'h3A; 7'h52: return 7'h22;
      7'h41: return 7'h3C; 7'h49: return 7'h3E; 7'h4A: return 7'h3F;
      default: begin
        p = plain_key(c);
        return (p >= 7'h61 && p <= 7'h7A) ? p - 7'h20 : p;
      end
    endcase
  endfunction

  logic [6:0] rom [256];
  for (genvar i = 0; i < 256; i++) begin : g_rom
    if (i >= 128) begin : g_hi
      assign rom[i] = shift_key(7'(i - 128));
    end else begin : g_lo
      assign rom[i] = plain_key(7'(i));
    end
  end

  mode_t         mode_q;
  logic [7:0]    prev_q;
  logic          shift_q;
  logic [CW-1:0] skip_q;

  logic       after_brk, is_shift, emit;
  logic [6:0] lut;

  assign after_brk = (prev_q == BRK);
  assign is_shift  = (byte_data == SH_L) || (byte_data == SH_R);
  assign lut       = rom[{shift_q, byte_data[6:0]}];
  assign emit      = byte_valid && (mode_q == M_NORM) && !byte_data[7] && !after_brk && (lut != 7'h00);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= M_NORM;
      prev_q     <= 8'h00;
      shift_q    <= 1'b0;
      skip_q     <= '0;
      char_valid <= 1'b0;
      char_code  <= 7'h00;
    end else begin
      char_valid <= emit;
      if (emit) char_code <= lut;
      if (byte_valid) begin
        case (mode_q)
          M_NORM: begin
            prev_q <= byte_data;
            if (byte_data == PFX_EXT) mode_q <= M_EXT;
            else if (byte_data == PFX_PAU) begin
              mode_q <= M_PAUSE;
              skip_q <= CW'(PAUSE_TAIL);
            end else if (is_shift) shift_q <= !after_brk;
          end
          M_EXT: begin
            if (byte_data != BRK) begin
              mode_q <= M_NORM;
              prev_q <= 8'h00;
            end
          end
          default: begin
            skip_q <= skip_q - 1'b1;
            if (skip_q <= CW'(1)) begin
              mode_q <= M_NORM;
              prev_q <= 8'h00;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/kbd_ascii_xlate_chk.sv
module kbd_ascii_xlate_chk (
  input logic       clk,
  input logic       rst,
  input logic       byte_valid,
  input logic [7:0] byte_data,
  input logic       char_valid,
  input logic [6:0] char_code,
  input logic [1:0] mode_q,
  input logic [7:0] prev_q,
  input logic       shift_q
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!char_valid && !shift_q && char_code == 7'h00));

  assert_break_silent_R2: assert property (@(posedge clk) disable iff (rst)
    (byte_valid && mode_q == 2'd0 && prev_q == 8'hF0) |=> !char_valid);

  assert_shift_set_R3: assert property (@(posedge clk) disable iff (rst)
    (byte_valid && mode_q == 2'd0 && prev_q != 8'hF0 && (byte_data == 8'h12 || byte_data == 8'h59)) |=> shift_q);

  assert_shift_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (byte_valid && mode_q == 2'd0 && prev_q == 8'hF0 && (byte_data == 8'h12 || byte_data == 8'h59)) |=> !shift_q);

  assert_nonzero_char_R6: assert property (@(posedge clk) disable iff (rst)
    char_valid |-> (char_code != 7'h00));

  assert_ext_silent_R7: assert property (@(posedge clk) disable iff (rst)
    (byte_valid && mode_q == 2'd1) |=> (!char_valid && $stable(shift_q)));

  assert_pause_silent_R8: assert property (@(posedge clk) disable iff (rst)
    (byte_valid && mode_q == 2'd2) |=> (!char_valid && $stable(shift_q)));

  assert_high_byte_silent_R10: assert property (@(posedge clk) disable iff (rst)
    (byte_valid && byte_data[7]) |=> !char_valid);

  assert_idle_silent_R11: assert property (@(posedge clk) disable iff (rst)
    !byte_valid |=> !char_valid);
endmodule

bind kbd_ascii_xlate kbd_ascii_xlate_chk u_chk (
  .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_data(byte_data),
  .char_valid(char_valid), .char_code(char_code),
  .mode_q(mode_q), .prev_q(prev_q), .shift_q(shift_q)
);

// File: tb/kbd_ascii_xlate_tb.sv
`timescale 1ns/1ps
module kbd_ascii_xlate_tb;
  logic clk = 1'b0, rst = 1'b1, byte_valid = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic char_valid;
  logic [6:0] char_code;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  kbd_ascii_xlate u_dut (.clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_data(byte_data),
                         .char_valid(char_valid), .char_code(char_code));

  function automatic logic [23:0] v(input int r, input logic [7:0] b, input logic e, input logic [6:0] c);
    return {8'(r), b, e, c};
  endfunction

  localparam int NV = 52;
  localparam logic [23:0] VEC [NV] = '{
    v(2,8'h4B,1,7'h6C), v(2,8'hF0,0,0), v(2,8'h4B,0,0),                            // R2 tap 'l'
    v(3,8'h12,0,0), v(3,8'h4B,1,7'h4C), v(3,8'hF0,0,0), v(3,8'h4B,0,0),           // R3 left shift
    v(4,8'hF0,0,0), v(4,8'h12,0,0), v(4,8'h16,1,7'h31), v(4,8'hF0,0,0), v(4,8'h16,0,0), // R4
    v(3,8'h59,0,0), v(3,8'h15,1,7'h51), v(3,8'hF0,0,0), v(3,8'h15,0,0),           // R3 right shift
    v(4,8'hF0,0,0), v(4,8'h59,0,0), v(4,8'h15,1,7'h71), v(4,8'hF0,0,0), v(4,8'h15,0,0),
    v(5,8'h1C,1,7'h61), v(5,8'h1C,1,7'h61), v(5,8'h1C,1,7'h61), v(5,8'hF0,0,0), v(5,8'h1C,0,0), // R5
    v(6,8'h14,0,0), v(6,8'h05,0,0), v(6,8'hF0,0,0), v(6,8'h14,0,0),               // R6
    v(7,8'hE0,0,0), v(7,8'h12,0,0), v(7,8'h4B,1,7'h6C),                            // R7 no shift
    v(7,8'hE0,0,0), v(7,8'hF0,0,0), v(7,8'h75,0,0), v(7,8'h16,1,7'h31),            // R7 ext release
    v(3,8'h12,0,0),
    v(8,8'hE1,0,0), v(8,8'h14,0,0), v(8,8'h77,0,0), v(8,8'hE1,0,0),                // R8 pause
    v(8,8'hF0,0,0), v(8,8'h14,0,0), v(8,8'hF0,0,0), v(8,8'h77,0,0), v(8,8'h15,1,7'h51),
    v(12,8'h0E,1,7'h7E), v(12,8'h5A,1,7'h0D),                                      // R12
    v(4,8'hF0,0,0), v(4,8'h12,0,0), v(10,8'hAA,0,0)                                // R10
  };

  task automatic fail(input string req, input int act, input int exp);
    errors++;
    $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
  endtask

  task automatic send(input logic [7:0] b, input logic ev, input logic [6:0] ec, input int r);
    byte_data  = b;
    byte_valid = 1'b1;
    @(negedge clk);
    byte_valid = 1'b0;
    checks++;
    if (char_valid !== ev) fail($sformatf("R%0d valid byte %0h", r, b), char_valid, ev);
    else if (ev && char_code !== ec) fail($sformatf("R%0d code byte %0h", r, b), char_code, ec);
    @(negedge clk);
    checks++;
    if (char_valid !== 1'b0) fail("R9 strobe width", char_valid, 0);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (char_valid !== 1'b0 || char_code !== 7'h00) fail("R1 reset outputs", {char_valid, char_code}, 0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++)
      send(VEC[i][15:8], VEC[i][7], VEC[i][6:0], int'(VEC[i][23:16]));

    // R11: data toggling without valid
    byte_data = 8'h4B;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      checks++;
      if (char_valid !== 1'b0) fail("R11 idle strobe", char_valid, 0);
    end

    // R5/R9: back-to-back bytes give back-to-back strobes
    byte_data = 8'h1C; byte_valid = 1'b1;
    @(negedge clk);
    checks++;
    if (char_valid !== 1'b1 || char_code !== 7'h61) fail("R5 first back-to-back", {char_valid, char_code}, 8'hE1);
    byte_data = 8'h32;
    @(negedge clk);
    byte_valid = 1'b0;
    checks++;
    if (char_valid !== 1'b1 || char_code !== 7'h62) fail("R5 second back-to-back", {char_valid, char_code}, 8'hE2);
    @(negedge clk);
    checks++;
    if (char_valid !== 1'b0) fail("R9 strobe after burst", char_valid, 0);

    // R1: reset clears shift, last-byte and skip state
    send(8'h12, 0, 0, 1);
    send(8'hE1, 0, 0, 1);
    rst = 1'b1;
    @(negedge clk);
    checks++;
    if (char_valid !== 1'b0 || char_code !== 7'h00) fail("R1 outputs in reset", {char_valid, char_code}, 0);
    rst = 1'b0;
    @(negedge clk);
    send(8'h4B, 1, 7'h6C, 1);
    send(8'hF0, 0, 0, 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    send(8'h4B, 1, 7'h6C, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule